// File: doc/BRIEF.md
# Transfer Word Sample Packer and Unpacker

This block sits between a sample stream and a stream of fixed 32-bit transfer words. The pack path collects samples into transfer words. The unpack path splits transfer words back into samples. The two paths run side by side under one shared format setting, and every stream uses a valid/ready handshake.

Four formats are supported:
- a full 32-bit sample per word;
- two 16-bit samples per word;
- one 16-bit sample per word, in a selectable half;
- three 10-bit samples per word.

Samples cross the sample-side ports right-aligned in a 32-bit field. A flush request pushes out a partly filled word. A format write is refused while any data is held inside the block.

Top module: `sample_word_codec`

## Requirements
- R1: After synchronous reset, `w_out_valid`, `s_out_valid` and `cfg_err` are low, `s_in_ready` and `w_in_ready` are high, the format is full-word (code 0) and the half select is low.
- R2: Format codes are 0 for full-word, 1 for two 16-bit samples, 2 for one 16-bit sample and 3 for three 10-bit samples. In full-word format each sample maps unchanged to one word and each word to one sample.
- R3: In format 1 the first sample of a word fills bits [15:0] and the second fills bits [31:16]. Unpacking yields the low half first, then the high half. Sample input bits above bit 15 are ignored.
- R4: In format 2 each word holds one sample. The half select gives bits [31:16] when high and bits [15:0] when low. Packing drives the other half to zero, and unpacking ignores the other half.
- R5: In format 3 the three samples fill bits [9:0], [19:10] and [29:20] in arrival order, and bits [31:30] are zero. Sample input bits above bit 9 are ignored.
- R6: Every unpacked sample leaves zero-extended in the format's sample width.
- R7: Flush behaviour:
  - When `flush` is high, no sample is offered and the accumulator holds at least one sample, the partial word is emitted with its empty slots at zero and the accumulator restarts at slot 0.
  - A flush while the accumulator is empty emits nothing.
- R8: A `cfg_wr` takes effect only when no partial word, pending output word or unpack word is held. Otherwise the format stays unchanged and `cfg_err` is high for exactly the following cycle.
- R9: While `w_out_valid` is high and `w_out_ready` is low, `w_out_data` holds steady. The same holds for `s_out_valid`, `s_out_ready` and `s_out_data`.
- R10: With ready held high downstream, the pack path accepts one sample per clock. The unpack path delivers one sample per clock across word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Format write request |
| cfg_fmt | input | 2 | Requested format code |
| cfg_hi | input | 1 | Requested half select for format 2 |
| cfg_err | output | 1 | One-cycle pulse for a refused format write |
| s_in_valid | input | 1 | Pack path sample valid |
| s_in_ready | output | 1 | Pack path sample ready |
| s_in_data | input | 32 | Pack path sample, right-aligned |
| flush | input | 1 | Emit the partial word |
| w_out_valid | output | 1 | Packed word valid |
| w_out_ready | input | 1 | Packed word ready |
| w_out_data | output | 32 | Packed word |
| w_in_valid | input | 1 | Unpack path word valid |
| w_in_ready | output | 1 | Unpack path word ready |
| w_in_data | input | 32 | Unpack path word |
| s_out_valid | output | 1 | Unpacked sample valid |
| s_out_ready | input | 1 | Unpacked sample ready |
| s_out_data | output | 32 | Unpacked sample, zero-extended |

## Verification
A slot counter that drifts by one puts a sample in the wrong lane of the very next word or sample leaving the block. It therefore shows within one word time. Stale accumulator bits appear as nonzero empty slots in the next flushed or unused-half word.

A wrong idle indication shows one cycle after a format write, either as a spurious `cfg_err` pulse or as a format that changed mid-word. The word after that decodes with the wrong lane layout. A broken hold under backpressure shows as output data that changes while valid is high and ready is low.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int WORD_W   = 32;
    localparam int HALF_W   = WORD_W / 2;
    localparam int NARROW_W = 10;
    localparam int SLOT_W   = 2;

    typedef enum logic [1:0] {
        FMT_W32 = 2'd0,
        FMT_P16 = 2'd1,
        FMT_U16 = 2'd2,
        FMT_P10 = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic hi_half;
    } cfg_t;

    function automatic logic [SLOT_W-1:0] last_slot(fmt_e f);
        case (f)
            FMT_P16: return 2'd1;
            FMT_P10: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] half_lane(logic hi, logic [HALF_W-1:0] v);
        return hi ? {v, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] place(cfg_t c, logic [SLOT_W-1:0] slot,
                                                logic [WORD_W-1:0] s);
        logic [WORD_W-1:0] narrow;
        narrow = {{(WORD_W-NARROW_W){1'b0}}, s[NARROW_W-1:0]};
        case (c.fmt)
            FMT_P16: return half_lane(slot[0], s[HALF_W-1:0]);
            FMT_U16: return half_lane(c.hi_half, s[HALF_W-1:0]);
            FMT_P10: return narrow << (NARROW_W * int'(slot));
            default: return s;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] extract(cfg_t c, logic [SLOT_W-1:0] slot,
                                                  logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] shifted;
        shifted = w >> (NARROW_W * int'(slot));
        case (c.fmt)
            FMT_P16: return slot[0] ? {{HALF_W{1'b0}}, w[WORD_W-1:HALF_W]}
                                    : {{HALF_W{1'b0}}, w[HALF_W-1:0]};
            FMT_U16: return c.hi_half ? {{HALF_W{1'b0}}, w[WORD_W-1:HALF_W]}
                                      : {{HALF_W{1'b0}}, w[HALF_W-1:0]};
            FMT_P10: return {{(WORD_W-NARROW_W){1'b0}}, shifted[NARROW_W-1:0]};
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/swc_cfg.sv
module swc_cfg
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_fmt,
    input  logic       cfg_hi,
    input  logic       busy,
    output cfg_t       cfg_q,
    output logic       cfg_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.fmt     <= FMT_W32;
            cfg_q.hi_half <= 1'b0;
            cfg_err       <= 1'b0;
        end else begin
            cfg_err <= 1'b0;
            if (cfg_wr) begin
                if (busy) begin
                    cfg_err <= 1'b1;
                end else begin
                    cfg_q.fmt     <= fmt_e'(cfg_fmt);
                    cfg_q.hi_half <= cfg_hi;
                end
            end
        end
    end

endmodule

// File: rtl/swc_pack.sv
module swc_pack
    import swc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    input  logic              flush,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [WORD_W-1:0] w_data,
    output logic              busy
);

    logic [WORD_W-1:0] acc;
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] merged;
    logic              out_free;
    logic              take;
    logic              full;
    logic              flush_go;

    assign out_free = !w_valid || w_ready;
    assign s_ready  = out_free;
    assign take     = s_valid && out_free;
    assign merged   = acc | place(cfg, slot, s_data);
    assign full     = (slot == last_slot(cfg.fmt));
    assign flush_go = flush && !s_valid && (slot != '0) && out_free;
    assign busy     = w_valid || (slot != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            slot    <= '0;
            w_valid <= 1'b0;
            w_data  <= '0;
        end else begin
            if (w_valid && w_ready) begin
                w_valid <= 1'b0;
            end
            if (take) begin
                if (full) begin
                    w_data  <= merged;
                    w_valid <= 1'b1;
                    acc     <= '0;
                    slot    <= '0;
                end else begin
                    acc  <= merged;
                    slot <= slot + 2'd1;
                end
            end else if (flush_go) begin
                w_data  <= acc;
                w_valid <= 1'b1;
                acc     <= '0;
                slot    <= '0;
            end
        end
    end

endmodule

// File: rtl/swc_unpack.sv
module swc_unpack
    import swc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [WORD_W-1:0] w_data,
    output logic              s_valid,
    input  logic              s_ready,
    output logic [WORD_W-1:0] s_data,
    output logic              busy
);

    logic [WORD_W-1:0] wbuf;
    logic [SLOT_W-1:0] idx;
    logic              have;
    logic              at_last;

    assign at_last = (idx == last_slot(cfg.fmt));
    assign s_valid = have;
    assign s_data  = extract(cfg, idx, wbuf);
    assign w_ready = !have || (s_ready && at_last);
    assign busy    = have;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf <= '0;
            idx  <= '0;
            have <= 1'b0;
        end else if (have && s_ready) begin
            if (at_last) begin
                idx  <= '0;
                have <= w_valid;
                if (w_valid) begin
                    wbuf <= w_data;
                end
            end else begin
                idx <= idx + 2'd1;
            end
        end else if (!have && w_valid) begin
            have <= 1'b1;
            wbuf <= w_data;
            idx  <= '0;
        end
    end

endmodule

// File: rtl/sample_word_codec.sv
module sample_word_codec
    import swc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_hi,
    output logic              cfg_err,
    input  logic              s_in_valid,
    output logic              s_in_ready,
    input  logic [WORD_W-1:0] s_in_data,
    input  logic              flush,
    output logic              w_out_valid,
    input  logic              w_out_ready,
    output logic [WORD_W-1:0] w_out_data,
    input  logic              w_in_valid,
    output logic              w_in_ready,
    input  logic [WORD_W-1:0] w_in_data,
    output logic              s_out_valid,
    input  logic              s_out_ready,
    output logic [WORD_W-1:0] s_out_data
);

    cfg_t cfg_q;
    logic pack_busy;
    logic unpack_busy;
    logic cfg_busy;

    assign cfg_busy = pack_busy || unpack_busy;

    swc_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr),
        .cfg_fmt (cfg_fmt),
        .cfg_hi  (cfg_hi),
        .busy    (cfg_busy),
        .cfg_q   (cfg_q),
        .cfg_err (cfg_err)
    );

    swc_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .s_valid (s_in_valid),
        .s_ready (s_in_ready),
        .s_data  (s_in_data),
        .flush   (flush),
        .w_valid (w_out_valid),
        .w_ready (w_out_ready),
        .w_data  (w_out_data),
        .busy    (pack_busy)
    );

    swc_unpack u_unpack (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .w_valid (w_in_valid),
        .w_ready (w_in_ready),
        .w_data  (w_in_data),
        .s_valid (s_out_valid),
        .s_ready (s_out_ready),
        .s_data  (s_out_data),
        .busy    (unpack_busy)
    );

endmodule

// File: rtl/swc_checker.sv
module swc_checker
    import swc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              cfg_err,
    input logic              busy,
    input cfg_t              cfg,
    input logic              w_out_valid,
    input logic              w_out_ready,
    input logic [WORD_W-1:0] w_out_data,
    input logic              s_out_valid,
    input logic              s_out_ready,
    input logic [WORD_W-1:0] s_out_data
);

    AST_ERR_NEEDS_BUSY_WRITE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(cfg_wr && busy)); // R8

    AST_CFG_KEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && busy) |=> $stable(cfg)); // R8

    AST_WORD_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (w_out_valid && !w_out_ready) |=> (w_out_valid && $stable(w_out_data))); // R9

    AST_SAMPLE_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_out_valid && !s_out_ready) |=> (s_out_valid && $stable(s_out_data))); // R9

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (w_out_valid && cfg.fmt == FMT_P10) |-> (w_out_data[31:30] == 2'b00)); // R5

    AST_SINGLE_HALF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (w_out_valid && cfg.fmt == FMT_U16) |->
        (cfg.hi_half ? (w_out_data[15:0] == '0) : (w_out_data[31:16] == '0))); // R4

    AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (s_out_valid && cfg.fmt == FMT_P10) |-> (s_out_data[31:10] == '0)); // R6

endmodule

bind sample_word_codec swc_checker u_swc_checker (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_err     (cfg_err),
    .busy        (cfg_busy),
    .cfg         (cfg_q),
    .w_out_valid (w_out_valid),
    .w_out_ready (w_out_ready),
    .w_out_data  (w_out_data),
    .s_out_valid (s_out_valid),
    .s_out_ready (s_out_ready),
    .s_out_data  (s_out_data)
);

// File: tb/test_sample_word_codec.sv
module test_sample_word_codec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_hi = 1'b0;
    logic        cfg_err;
    logic        s_in_valid = 1'b0;
    logic        s_in_ready;
    logic [31:0] s_in_data = '0;
    logic        flush = 1'b0;
    logic        w_out_valid;
    logic        w_out_ready = 1'b1;
    logic [31:0] w_out_data;
    logic        w_in_valid = 1'b0;
    logic        w_in_ready;
    logic [31:0] w_in_data = '0;
    logic        s_out_valid;
    logic        s_out_ready = 1'b1;
    logic [31:0] s_out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] wcap [16];
    logic [31:0] scap [16];
    int          scyc [16];
    int          wn = 0;
    int          sn = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    sample_word_codec i_sample_word_codec (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt), .cfg_hi(cfg_hi), .cfg_err(cfg_err),
        .s_in_valid(s_in_valid), .s_in_ready(s_in_ready), .s_in_data(s_in_data),
        .flush(flush),
        .w_out_valid(w_out_valid), .w_out_ready(w_out_ready), .w_out_data(w_out_data),
        .w_in_valid(w_in_valid), .w_in_ready(w_in_ready), .w_in_data(w_in_data),
        .s_out_valid(s_out_valid), .s_out_ready(s_out_ready), .s_out_data(s_out_data)
    );

    // Handshake monitor, sampled well after the falling edge when all inputs are settled
    always @(negedge clk) begin
        #2;
        if (w_out_valid && w_out_ready) begin
            if (wn < 16) wcap[wn] = w_out_data;
            wn++;
        end
        if (s_out_valid && s_out_ready) begin
            if (sn < 16) begin
                scap[sn] = s_out_data;
                scyc[sn] = cyc;
            end
            sn++;
        end
        cyc++;
    end

    // fmt, hi, s0, s1, s2, expected word
    localparam logic [130:0] VEC [7] = '{
        {2'd0, 1'b0, 32'hDEADBEEF, 32'h0,        32'h0,        32'hDEADBEEF},
        {2'd1, 1'b0, 32'h00001234, 32'h0000ABCD, 32'h0,        32'hABCD1234},
        {2'd1, 1'b0, 32'hFFFF0001, 32'h00058002, 32'h0,        32'h80020001},
        {2'd2, 1'b0, 32'h7777BEEF, 32'h0,        32'h0,        32'h0000BEEF},
        {2'd2, 1'b1, 32'h1234CAFE, 32'h0,        32'h0,        32'hCAFE0000},
        {2'd3, 1'b0, 32'h000003FF, 32'h00000001, 32'h00000155, 32'h155007FF},
        {2'd3, 1'b0, 32'h000002AA, 32'hFFFFFFFF, 32'h000007FF, 32'h3FFFFEAA}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(logic [1:0] f, logic h, logic exp_err, string tag);
        cfg_fmt = f;
        cfg_hi  = h;
        cfg_wr  = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        #2;
        check(tag, {31'd0, cfg_err}, {31'd0, exp_err});
        @(negedge clk);
    endtask

    task automatic send_sample(logic [31:0] d);
        s_in_data  = d;
        s_in_valid = 1'b1;
        #1;
        while (!s_in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic send_word(logic [31:0] d);
        w_in_data  = d;
        w_in_valid = 1'b1;
        #1;
        while (!w_in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    function automatic string fmt_tag(logic [1:0] f);
        case (f)
            2'd1:    return "R3";
            2'd2:    return "R4";
            2'd3:    return "R5";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(logic [1:0] f);
        case (f)
            2'd1, 2'd2: return 32'h0000FFFF;
            2'd3:       return 32'h000003FF;
            default:    return 32'hFFFFFFFF;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R10: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [130:0] v;
        logic [1:0]   f;
        logic         h;
        logic [31:0]  s [3];
        logic [31:0]  ew;
        logic [31:0]  junk;
        int           n;
        time          t0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state
        check("R1 w_out_valid", {31'd0, w_out_valid}, 32'd0);
        check("R1 s_out_valid", {31'd0, s_out_valid}, 32'd0);
        check("R1 cfg_err",     {31'd0, cfg_err},     32'd0);
        check("R1 s_in_ready",  {31'd0, s_in_ready},  32'd1);
        check("R1 w_in_ready",  {31'd0, w_in_ready},  32'd1);
        @(negedge clk);

        // R1: default format is full-word, one sample per word
        wn = 0;
        send_sample(32'h0BADF00D);
        s_in_valid = 1'b0;
        tick(2);
        check("R1 default fmt count", 32'(wn), 32'd1);
        check("R1 default fmt word", wcap[0], 32'h0BADF00D);

        // Table walk: pack then unpack each vector
        for (int i = 0; i < 7; i++) begin
            v    = VEC[i];
            f    = v[130:129];
            h    = v[128];
            s[0] = v[127:96];
            s[1] = v[95:64];
            s[2] = v[63:32];
            ew   = v[31:0];
            n    = (f == 2'd3) ? 3 : (f == 2'd1) ? 2 : 1;
            configure(f, h, 1'b0, "R8 idle write accepted");
            wn = 0;
            sn = 0;
            for (int k = 0; k < n; k++) send_sample(s[k]);
            s_in_valid = 1'b0;
            tick(3);
            check({fmt_tag(f), " pack count"}, 32'(wn), 32'd1);
            check({fmt_tag(f), " pack word"}, wcap[0], ew);
            junk = (f == 2'd2) ? (h ? 32'h0000FFFF : 32'hFFFF0000) : 32'h0;
            send_word(ew ^ junk);
            w_in_valid = 1'b0;
            tick(5);
            check({fmt_tag(f), " unpack count"}, 32'(sn), 32'(n));
            for (int k = 0; k < n; k++)
                check({fmt_tag(f), " R6 unpack sample"}, scap[k], s[k] & lane_mask(f));
        end

        // R7: flush on empty accumulator, then partial word
        configure(2'd3, 1'b0, 1'b0, "R8 idle write accepted");
        wn = 0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        tick(2);
        check("R7 empty flush emits nothing", 32'(wn), 32'd0);
        send_sample(32'h011);
        send_sample(32'h022);
        s_in_valid = 1'b0;
        tick(2);
        check("R7 partial not emitted early", 32'(wn), 32'd0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        tick(2);
        check("R7 flush count", 32'(wn), 32'd1);
        check("R7 flush word", wcap[0], 32'h00008811);
        send_sample(32'h1);
        send_sample(32'h2);
        send_sample(32'h3);
        s_in_valid = 1'b0;
        tick(2);
        check("R7 restart at slot 0", wcap[1], 32'h00300801);

        // R8: refused write while the pack accumulator is partial
        configure(2'd1, 1'b0, 1'b0, "R8 idle write accepted");
        wn = 0;
        send_sample(32'h1111);
        s_in_valid = 1'b0;
        configure(2'd0, 1'b0, 1'b1, "R8 busy pack write flagged");
        #2;
        check("R8 err is one cycle", {31'd0, cfg_err}, 32'd0);
        @(negedge clk);
        send_sample(32'h2222);
        s_in_valid = 1'b0;
        tick(2);
        check("R8 format kept after refusal", wcap[0], 32'h22221111);

        // R8: refused write while the unpack path holds a word
        configure(2'd3, 1'b0, 1'b0, "R8 idle write accepted");
        s_out_ready = 1'b0;
        sn = 0;
        send_word(32'h155007FF);
        w_in_valid = 1'b0;
        configure(2'd1, 1'b0, 1'b1, "R8 busy unpack write flagged");
        s_out_ready = 1'b1;
        tick(5);
        check("R8 unpack count", 32'(sn), 32'd3);
        check("R8 unpack lane0", scap[0], 32'h3FF);
        check("R8 unpack lane2", scap[2], 32'h155);

        // R9: pack output held under backpressure
        configure(2'd1, 1'b0, 1'b0, "R8 idle write accepted");
        w_out_ready = 1'b0;
        wn = 0;
        send_sample(32'h1);
        send_sample(32'h2);
        s_in_data = 32'h3;
        tick(1);
        #2;
        check("R9 word valid under stall", {31'd0, w_out_valid}, 32'd1);
        check("R9 word data under stall", w_out_data, 32'h00020001);
        check("R9 input stalled", {31'd0, s_in_ready}, 32'd0);
        tick(2);
        #2;
        check("R9 word still held", w_out_data, 32'h00020001);
        @(negedge clk);
        w_out_ready = 1'b1;
        @(negedge clk);
        s_in_data = 32'h4;
        @(negedge clk);
        s_in_valid = 1'b0;
        tick(2);
        check("R9 words after release", 32'(wn), 32'd2);
        check("R9 second word", wcap[1], 32'h00040003);

        // R9: unpack output held under backpressure
        configure(2'd1, 1'b0, 1'b0, "R8 idle write accepted");
        s_out_ready = 1'b0;
        sn = 0;
        send_word(32'hBBBBAAAA);
        w_in_valid = 1'b0;
        tick(1);
        #2;
        check("R9 sample held", s_out_data, 32'h0000AAAA);
        tick(2);
        #2;
        check("R9 sample still held", s_out_data, 32'h0000AAAA);
        @(negedge clk);
        s_out_ready = 1'b1;
        tick(3);
        check("R9 unpack after release", 32'(sn), 32'd2);
        check("R9 high half second", scap[1], 32'h0000BBBB);

        // R10: one sample per clock on both paths
        configure(2'd1, 1'b0, 1'b0, "R8 idle write accepted");
        wn = 0;
        t0 = $time;
        for (int k = 0; k < 8; k++) send_sample(32'(k + 16));
        s_in_valid = 1'b0;
        check("R10 pack cycles", 32'(($time - t0) / 20), 32'd8);
        tick(2);
        check("R10 pack words", 32'(wn), 32'd4);
        check("R10 last pack word", wcap[3], 32'h00170016);

        configure(2'd3, 1'b0, 1'b0, "R8 idle write accepted");
        sn = 0;
        send_word(32'h155007FF);
        send_word(32'h3FFFFEAA);
        w_in_valid = 1'b0;
        tick(8);
        check("R10 unpack count", 32'(sn), 32'd6);
        check("R10 unpack back to back", 32'(scyc[5] - scyc[0]), 32'd5);
        check("R10 second word lane0", scap[3], 32'h2AA);
        check("R10 second word lane2", scap[5], 32'h3FF);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule